// File: doc/BRIEF.md
# Two-Step Flash Result Assembler

This block is the digital back end of a two-step subranging converter that delivers a 10-bit code. A 6-comparator coarse estimator first reports a thermometer code. The block turns that code into a window index. The window index tells the analog side which group of sixteen ladder taps to route to a shared bank of 16 comparators. Those comparators are then read twice. The first reading, the coarse flash, is combined with the window index to form the 6 most significant bits. The second reading, the fine flash, is taken against the residue and supplies the 4 least significant bits.

Each window spans four sixteenths of full scale. The estimator's decision regions are only two sixteenths wide, so every window reaches one sixteenth past its region on each side. An estimator that picks the neighbouring window for an input close to a boundary is therefore absorbed by the arithmetic, and the assembled code is still exact. Thermometer codes are decoded by counting ones, so misordered comparator outputs (bubbles) do no harm.

A conversion is started by `start`. It then moves through four phases, one for each clock cycle in which `step` is high: estimate capture, coarse capture, fine capture and latch. The code output changes only in the latch cycle, and `done` pulses at the same time.

Top module: `ts_flash_assembler`

## Requirements
- R1: After synchronous reset, `code`, `tap_msb` and `win_idx` are 0, and `done` and `busy` are low.
- R2: In the estimate phase, a clock with `step` high loads `win_idx` with the number of ones in `est_therm`, a value from 0 to 6. `win_idx` keeps that value until the next estimate capture. Window `w` starts at `128*w` LSB, which is `8*w` in units of `tap_msb`.
- R3: Bit `j` of `flash_therm` during the coarse phase is the comparator at tap `128*win_idx + 16*j`. A step in that phase loads `tap_msb` with `8*win_idx + c - 1`, where `c` is the number of ones. An all-zero coarse reading saturates to the window's lower edge, `8*win_idx`.
- R4: Bit `j` of `flash_therm` during the fine phase fires when the residue is at least `j+1` LSB. The 4 LSBs equal the number of ones, and an all-ones reading (16) saturates to 15.
- R5: `code` is `{tap_msb, fine LSBs}`. It changes only at the clock of the step taken in the latch phase. `done` is high for exactly that one clock cycle, and `code` holds its value at every other time.
- R6: `start` in idle raises `busy`. Each cycle with `step` high advances one phase: estimate, coarse, fine (`fine_phase` high), latch, then idle. Cycles with `step` low leave the phase unchanged.
- R7: `start` has no effect while a conversion is in progress. `step` has no effect in idle: `busy`, `done` and `code` stay unchanged.
- R8: For every input level `v` from 0 to 1023, and for any window `w` with `128*w <= v < 128*w + 256`, the assembled `code` equals `v`. This covers estimator errors of one window in either direction.
- R9: A thermometer input with adjacent bits swapped (a bubble) yields the same result as the clean code with the same number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| step | input | 1 | Clock enable that advances one phase |
| est_therm | input | 6 | Coarse estimator comparator outputs |
| flash_therm | input | 16 | Shared 16-comparator bank outputs |
| busy | output | 1 | Conversion in progress |
| fine_phase | output | 1 | Analog side should present the residue |
| win_idx | output | 3 | Selected tap window |
| tap_msb | output | 6 | Corrected 6 MSBs; also selects the residue tap |
| code | output | 10 | Latched conversion result |
| done | output | 1 | One-cycle pulse when `code` is updated |

## Verification
A wrong window index appears on `win_idx` one clock after the estimate step. It also shifts the tap positions the comparator model sees, so `tap_msb` goes wrong one step later. Broken overlap correction or broken saturation shows at the coarse step as a `tap_msb` outside the window or away from `v/16`. Fine-flash faults show only in the latched `code`. Sequencer faults show as `done` arriving early, late or for two cycles, or as `code` moving outside the latch cycle, and they are visible within one step of the fault.

// File: rtl/ts_flash_pkg.sv
package ts_flash_pkg;

    localparam int RES_BITS   = 10;
    localparam int EST_CMP    = 6;
    localparam int FLASH_CMP  = 16;

    localparam int LSB_BITS   = $clog2(FLASH_CMP);
    localparam int MSB_BITS   = RES_BITS - LSB_BITS;
    localparam int WIN_BITS   = $clog2(EST_CMP + 1);
    localparam int FCNT_BITS  = $clog2(FLASH_CMP + 1);
    localparam int WIN_STRIDE = (1 << MSB_BITS) / (EST_CMP + 2);

    typedef logic [WIN_BITS-1:0]  win_t;
    typedef logic [MSB_BITS-1:0]  msb_t;
    typedef logic [LSB_BITS-1:0]  lsb_t;
    typedef logic [FCNT_BITS-1:0] fcnt_t;

    typedef struct packed {
        msb_t msb;
        lsb_t lsb;
    } code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_EST,
        PH_COARSE,
        PH_FINE,
        PH_LATCH
    } phase_t;

    typedef struct packed {
        logic est;
        logic coarse;
        logic fine;
        logic latch;
    } capture_t;

    // lower edge of window w in MSB units
    function automatic msb_t window_base(input win_t w);
        return MSB_BITS'(w) * MSB_BITS'(WIN_STRIDE);
    endfunction

    // coarse count c means taps 0..c-1 are below the input; empty clamps to edge
    function automatic lsb_t coarse_offset(input fcnt_t c);
        if (c == '0)
            return '0;
        return LSB_BITS'(c - 1'b1);
    endfunction

    // fine count of FLASH_CMP (all ones) clamps to the top step
    function automatic lsb_t fine_value(input fcnt_t c);
        if (c > FCNT_BITS'(FLASH_CMP - 1))
            return '1;
        return LSB_BITS'(c);
    endfunction

endpackage

// File: rtl/ts_therm_count.sv
module ts_therm_count #(
    parameter int N = 16,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] therm,
    output logic [W-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++)
            ones = ones + W'(therm[i]);
    end
endmodule

// File: rtl/ts_step_sequencer.sv
module ts_step_sequencer
    import ts_flash_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     step,
    output phase_t   phase,
    output capture_t cap
);
    phase_t phase_n;

    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_IDLE:   if (start) phase_n = PH_EST;
            PH_EST:    if (step)  phase_n = PH_COARSE;
            PH_COARSE: if (step)  phase_n = PH_FINE;
            PH_FINE:   if (step)  phase_n = PH_LATCH;
            PH_LATCH:  if (step)  phase_n = PH_IDLE;
            default:              phase_n = PH_IDLE;
        endcase
    end

    always_comb begin
        cap.est    = step && (phase == PH_EST);
        cap.coarse = step && (phase == PH_COARSE);
        cap.fine   = step && (phase == PH_FINE);
        cap.latch  = step && (phase == PH_LATCH);
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_n;
    end

    // R6: at most one capture per clock
    p_one_capture_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap.est, cap.coarse, cap.fine, cap.latch}));

    // R6: phase only advances with step once running
    p_hold_without_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !step) |=> $stable(phase));

    // R7: idle stays idle without start, whatever step does
    p_idle_step_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

    // R6: a capture step leaves the phase it was taken in
    p_step_advances_r6: assert property (@(posedge clk) disable iff (rst)
        (cap.est || cap.coarse || cap.fine) |=> !$stable(phase));
endmodule

// File: rtl/ts_window_select.sv
module ts_window_select
    import ts_flash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic [WIN_BITS-1:0] est_ones,
    output win_t                win,
    output msb_t                base
);
    always_ff @(posedge clk) begin
        if (rst)      win <= '0;
        else if (cap) win <= est_ones;
    end

    assign base = window_base(win);

    // R2: the selected window never passes the last estimator region
    p_window_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        win <= WIN_BITS'(EST_CMP));

    // R2: window index holds between estimate captures
    p_window_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(win));
endmodule

// File: rtl/ts_coarse_merge.sv
module ts_coarse_merge
    import ts_flash_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  msb_t  base,
    input  fcnt_t flash_ones,
    output msb_t  msb
);
    msb_t msb_n;

    assign msb_n = base + MSB_BITS'(coarse_offset(flash_ones));

    always_ff @(posedge clk) begin
        if (rst)      msb <= '0;
        else if (cap) msb <= msb_n;
    end

    // R3: a captured coarse result stays inside the selected window
    p_msb_inside_window_r3: assert property (@(posedge clk) disable iff (rst)
        $past(cap) |-> (MSB_BITS'(msb - base) < MSB_BITS'(FLASH_CMP)));

    // R3: an empty coarse reading lands on the window's lower edge
    p_empty_coarse_floor_r3: assert property (@(posedge clk) disable iff (rst)
        $past(cap && flash_ones == '0) |-> (msb == base));
endmodule

// File: rtl/ts_flash_assembler.sv
module ts_flash_assembler
    import ts_flash_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 step,
    input  logic [EST_CMP-1:0]   est_therm,
    input  logic [FLASH_CMP-1:0] flash_therm,
    output logic                 busy,
    output logic                 fine_phase,
    output logic [WIN_BITS-1:0]  win_idx,
    output logic [MSB_BITS-1:0]  tap_msb,
    output logic [RES_BITS-1:0]  code,
    output logic                 done
);
    phase_t                phase;
    capture_t              cap;
    logic [WIN_BITS-1:0]   est_ones;
    fcnt_t                 flash_ones;
    win_t                  win;
    msb_t                  base;
    msb_t                  msb;
    lsb_t                  lsb;
    code_t                 result;

    ts_step_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .step  (step),
        .phase (phase),
        .cap   (cap)
    );

    ts_therm_count #(.N(EST_CMP), .W(WIN_BITS)) u_est_cnt (
        .therm (est_therm),
        .ones  (est_ones)
    );

    // one counter serves both readings of the shared comparator bank
    ts_therm_count #(.N(FLASH_CMP), .W(FCNT_BITS)) u_flash_cnt (
        .therm (flash_therm),
        .ones  (flash_ones)
    );

    ts_window_select u_win (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap.est),
        .est_ones (est_ones),
        .win      (win),
        .base     (base)
    );

    ts_coarse_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .cap        (cap.coarse),
        .base       (base),
        .flash_ones (flash_ones),
        .msb        (msb)
    );

    always_ff @(posedge clk) begin
        if (rst)           lsb <= '0;
        else if (cap.fine) lsb <= fine_value(flash_ones);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= cap.latch;
            if (cap.latch) begin
                result.msb <= msb;
                result.lsb <= lsb;
            end
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign fine_phase = (phase == PH_FINE);
    assign win_idx    = win;
    assign tap_msb    = msb;
    assign code       = result;

    // R5: done is a single-cycle pulse
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: the result moves only together with done
    p_code_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(code));

    // R5: done follows a step taken in the latch phase
    p_done_from_latch_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cap.latch));

    // R6: the conversion is over when done rises
    p_idle_at_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/sim_ts_flash_assembler.sv
module sim_ts_flash_assembler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic [5:0]  est_therm = '0;
    logic [15:0] flash_therm = '0;
    logic        busy, fine_phase, done;
    logic [2:0]  win_idx;
    logic [5:0]  tap_msb;
    logic [9:0]  code;

    int n_chk = 0;
    int n_fail = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ts_flash_assembler u0 (
        .clk(clk), .rst(rst), .start(start), .step(step),
        .est_therm(est_therm), .flash_therm(flash_therm),
        .busy(busy), .fine_phase(fine_phase), .win_idx(win_idx),
        .tap_msb(tap_msb), .code(code), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ideal estimator: boundaries at 3/16, 5/16 ... 13/16 of full scale
    function automatic int est_ideal(input int v);
        int e = 0;
        for (int k = 0; k < 6; k++)
            if (v >= 192 + 128 * k) e++;
        return e;
    endfunction

    function automatic bit win_ok(input int v, input int w);
        return (w >= 0) && (w <= 6) && (v >= 128 * w) && (v < 128 * w + 256);
    endfunction

    function automatic logic [5:0] therm6(input int n, input bit bub);
        logic [5:0] t;
        for (int i = 0; i < 6; i++) t[i] = (i < n);
        if (bub && n > 0 && n < 6) begin
            t[n-1] = 1'b0;
            t[n]   = 1'b1;
        end
        return t;
    endfunction

    function automatic logic [15:0] therm16(input int n, input bit bub);
        logic [15:0] t;
        for (int i = 0; i < 16; i++) t[i] = (i < n);
        if (bub && n > 0 && n < 16) begin
            t[n-1] = 1'b0;
            t[n]   = 1'b1;
        end
        return t;
    endfunction

    task automatic pulse_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full conversion of level v with comparator models driven from the ports
    task automatic run_conv(input int v, input int e, input bit bub, input int gap, input bit poke);
        logic [9:0] prev;
        int base, cnt, res;
        prev = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", busy, 1);
        est_therm = therm6(e, bub);
        idle_cycles(gap);
        pulse_step();
        chk("R2 window index", win_idx, e);
        base = 128 * win_idx;
        cnt = 0;
        for (int j = 0; j < 16; j++) if (v >= base + 16 * j) cnt++;
        flash_therm = therm16(cnt, bub);
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R7 start during coarse phase keeps phase", fine_phase, 0);
            chk("R7 start during coarse phase keeps busy", busy, 1);
        end
        idle_cycles(gap);
        pulse_step();
        chk("R8 corrected msb", tap_msb, v / 16);
        chk("R6 fine phase after coarse step", fine_phase, 1);
        res = v - 16 * tap_msb;
        cnt = (res < 0) ? 0 : ((res > 16) ? 16 : res);
        flash_therm = therm16(cnt, bub);
        idle_cycles(gap);
        pulse_step();
        chk("R5 code held before latch", code, prev);
        chk("R5 no done before latch", done, 0);
        idle_cycles(gap);
        pulse_step();
        chk("R5 done in latch cycle", done, 1);
        chk("R8 assembled code", code, v);
        @(negedge clk);
        chk("R5 done lasts one cycle", done, 0);
        chk("R6 idle after latch", busy, 0);
    endtask

    // conversion with fixed comparator readings
    task automatic raw_conv(input logic [5:0] est, input logic [15:0] crs, input logic [15:0] fin,
                            input int exp_win, input int exp_msb, input int exp_code, input string tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        est_therm = est;
        pulse_step();
        chk("R2 window from fixed estimate", win_idx, exp_win);
        flash_therm = crs;
        pulse_step();
        chk("R3 msb from fixed coarse reading", tap_msb, exp_msb);
        flash_therm = fin;
        pulse_step();
        pulse_step();
        chk(tag, code, exp_code);
        chk("R5 done with fixed readings", done, 1);
        @(negedge clk);
    endtask

    initial begin
        logic [9:0] held;
        void'($urandom(32'd7781));
        idle_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset code", code, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset window", win_idx, 0);
        chk("R1 reset msb", tap_msb, 0);

        held = code;
        pulse_step();
        pulse_step();
        chk("R7 step in idle keeps busy low", busy, 0);
        chk("R7 step in idle gives no done", done, 0);
        chk("R7 step in idle keeps code", code, held);

        // R3 empty coarse saturates to window floor; R4 full fine saturates to 15
        raw_conv(therm6(3, 0), 16'h0000, 16'hFFFF, 3, 24, 24 * 16 + 15, "R4 fine all-ones saturation");
        raw_conv(therm6(6, 0), 16'hFFFF, 16'h0000, 6, 63, 1008, "R5 code assembly at top window");
        // R9 bubbled readings: est ones=4, coarse ones=6, fine ones=4
        raw_conv(6'b010111, 16'h005F, 16'h002B, 4, 37, 37 * 16 + 4, "R9 bubble tolerance");

        held = code;
        pulse_step();
        chk("R7 idle step after conversions keeps code", code, held);

        // directed R8 corners
        run_conv(0, 0, 0, 0, 0);
        run_conv(1023, 6, 0, 1, 0);
        run_conv(255, 0, 0, 0, 1);
        run_conv(256, 2, 1, 2, 0);
        run_conv(191, 1, 0, 0, 0);
        run_conv(832, 5, 1, 0, 0);

        for (int v = 0; v < 1024; v++) begin
            int t, cand, e;
            t = est_ideal(v);
            cand = t + int'($urandom % 3) - 1;
            e = win_ok(v, cand) ? cand : t;
            if (e != t) n_err++;
            run_conv(v, e, bit'($urandom % 2), int'($urandom % 3), (v % 97) == 5);
        end
        chk("R8 estimator errors were injected", int'(n_err > 0), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual 0 expected 1 completed runs");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule